// File: doc/BRIEF.md
# Masked Repeating Time-of-Day Alarm

This block keeps four alarm registers for seconds, minutes, hours and day of month, all in BCD. It watches a running time of day that an external counter supplies, and when the fields it has been told to care about agree with that time it raises an interrupt that lasts one clock cycle. The comparison happens only when the one-second tick rises, so each matching second gives exactly one pulse.

Bit 7 of every alarm register is a mask bit. A masked field takes no part in the comparison. The way the four mask bits combine sets how often the alarm repeats: monthly, daily, hourly, once a minute or every second. Software programs the registers through a byte-wide write port. Each field checks its own write and ignores a value that is not a legal BCD number in range, so a bad write leaves the old contents in place. A combinational read port returns whichever register the address selects.

Top module: `masked_alarm`

## Requirements
- R1: After reset all four alarm registers read 0x00 and the interrupt is low.
- R2: Register addresses are 0 = seconds, 1 = minutes, 2 = hours, 3 = date. An accepted write stores the whole byte, bit 7 included, and reading that address returns it in the same cycle the address is presented.
- R3: A write to seconds or minutes is accepted only when bits 6:0 are a BCD value from 0 to 59. A nibble above 9 counts as illegal. A rejected write leaves the register unchanged.
- R4: A write to hours is accepted only when bits 5:0 are a BCD value from 0 to 23. Otherwise the register is unchanged.
- R5: A write to date is accepted only when bits 5:0 are a legal BCD value other than zero. Otherwise the register is unchanged.
- R6: With no mask bit set, the alarm fires only when date, hours, minutes and seconds all match the time of day.
- R7: With only the date mask set, the date is ignored and hours, minutes and seconds must match.
- R8: With the date and hour masks set and the minute and second masks clear, minutes and seconds must match.
- R9: With date, hour and minute masked and seconds unmasked, only the seconds must match.
- R10: Every other mask combination, including all four set and seconds alone set, fires on every tick.
- R11: The alarm is evaluated only on a rising edge of the tick. The interrupt is high for exactly the one cycle after the clock edge that sees that rise, and a tick held high for several cycles gives one pulse.
- R12: Seconds and minutes compare on bits 6:0 and hours and date compare on bits 5:0. Bit 6 of the hours and date registers takes no part in the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-second tick, sampled for a rising edge |
| todSec | input | 8 | Current seconds, BCD |
| todMin | input | 8 | Current minutes, BCD |
| todHour | input | 8 | Current hours, BCD |
| todDate | input | 8 | Current day of month, BCD |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select for write and read |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Contents of the selected register |
| alarmIrq | output | 1 | One-cycle alarm interrupt pulse |

## Verification
The bench builds the block with its default parameters: 8-bit registers, the mask in bit 7 and range limits of 59, 59, 23 and 39. With these values every range edge is reachable from the write port. That covers 59 against 60 for seconds, 23 against 24 for hours, a date of zero, and nibbles of A to F. The mask patterns the bench drives include each of the four ordered repeat rates as well as irregular patterns such as seconds alone or date with minutes, which must fall back to firing every second. A tick held high for three cycles checks the edge rule, and bit 6 of the hours register is set to show that it stays out of the match.

// File: rtl/masked_alarm_pkg.sv
package masked_alarm_pkg;

  localparam int FIELD_COUNT = 4;
  localparam int ADDR_W      = $clog2(FIELD_COUNT);

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_DATE = 3;

  typedef struct packed {
    logic [FIELD_COUNT-1:0] wrStb;
    logic                   evalTick;
  } ctrlStrobes_t;

  typedef enum logic [2:0] {
    RATE_MONTH,
    RATE_DAY,
    RATE_HOUR,
    RATE_MIN,
    RATE_SEC
  } repeatRate_e;

  // true when both nibbles are decimal digits and the value is within maxVal
  function automatic logic bcdInRange(input logic [3:0] hi, input logic [3:0] lo,
                                      input int maxVal);
    int value;
    value = int'(hi) * 10 + int'(lo);
    return (hi <= 4'd9) && (lo <= 4'd9) && (value <= maxVal);
  endfunction

  // 1 = compared bit, per field: seconds/minutes 6:0, hours/date 5:0
  function automatic logic [7:0] cmpMaskOf(input int idx);
    return (idx == IDX_SEC || idx == IDX_MIN) ? 8'h7F : 8'h3F;
  endfunction

endpackage

// File: rtl/masked_alarm_ctrl.sv
module masked_alarm_ctrl
  import masked_alarm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SEC_MAX  = 59,
  parameter int MIN_MAX  = 59,
  parameter int HOUR_MAX = 23,
  parameter int DATE_MAX = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrobes_t      stb
);

  logic                   tickQ;
  logic [FIELD_COUNT-1:0] fieldOk;
  logic [FIELD_COUNT-1:0] wrStbVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tickQ <= 1'b0;
    else        tickQ <= tick;
  end

  // per-field legality of the incoming byte
  always_comb begin
    fieldOk[IDX_SEC]  = bcdInRange({1'b0, regWrData[6:4]}, regWrData[3:0], SEC_MAX);
    fieldOk[IDX_MIN]  = bcdInRange({1'b0, regWrData[6:4]}, regWrData[3:0], MIN_MAX);
    fieldOk[IDX_HOUR] = bcdInRange({2'b0, regWrData[5:4]}, regWrData[3:0], HOUR_MAX);
    fieldOk[IDX_DATE] = bcdInRange({2'b0, regWrData[5:4]}, regWrData[3:0], DATE_MAX)
                        && (regWrData[5:0] != 6'd0);
  end

  for (genvar g = 0; g < FIELD_COUNT; g++) begin : g_wrDecode
    assign wrStbVec[g] = regWrEn && (regAddr == ADDR_W'(g)) && fieldOk[g];
  end

  always_comb begin
    stb.wrStb    = wrStbVec;
    stb.evalTick = tick & ~tickQ;
  end

  // R2: at most one register is written per cycle
  a_r2_one_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stb.wrStb));

  // R3: a seconds byte with a low nibble above 9 never reaches the register
  a_r3_bad_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (regWrEn && regAddr == ADDR_W'(IDX_SEC) && regWrData[3:0] > 4'd9)
      |-> !stb.wrStb[IDX_SEC]);

  // R11: a tick held high evaluates only once
  a_r11_eval_edge: assert property (@(posedge clk) disable iff (!rst_n)
    stb.evalTick |=> !stb.evalTick);

endmodule

// File: rtl/masked_alarm_datapath.sv
module masked_alarm_datapath
  import masked_alarm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MASK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] todSec,
  input  logic [DATA_W-1:0] todMin,
  input  logic [DATA_W-1:0] todHour,
  input  logic [DATA_W-1:0] todDate,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  logic [DATA_W-1:0]      alarmReg [FIELD_COUNT];
  logic [DATA_W-1:0]      todVec   [FIELD_COUNT];
  logic [FIELD_COUNT-1:0] fieldHit;
  logic [FIELD_COUNT-1:0] maskBits;
  repeatRate_e            rate;
  logic                   hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < FIELD_COUNT; i++) alarmReg[i] <= '0;
    end else begin
      for (int i = 0; i < FIELD_COUNT; i++)
        if (stb.wrStb[i]) alarmReg[i] <= wrData;
    end
  end

  assign rdData = alarmReg[rdAddr];

  always_comb begin
    todVec[IDX_SEC]  = todSec;
    todVec[IDX_MIN]  = todMin;
    todVec[IDX_HOUR] = todHour;
    todVec[IDX_DATE] = todDate;
  end

  for (genvar g = 0; g < FIELD_COUNT; g++) begin : g_field
    localparam logic [DATA_W-1:0] CMP = DATA_W'(cmpMaskOf(g));
    assign fieldHit[g] = ((alarmReg[g] ^ todVec[g]) & CMP) == '0;
    assign maskBits[g] = alarmReg[g][MASK_BIT];
  end

  // mask pattern {date,hour,min,sec} selects the repeat rate
  always_comb begin
    case (maskBits)
      4'b0000: rate = RATE_MONTH;
      4'b1000: rate = RATE_DAY;
      4'b1100: rate = RATE_HOUR;
      4'b1110: rate = RATE_MIN;
      default: rate = RATE_SEC;
    endcase
  end

  always_comb begin
    case (rate)
      RATE_MONTH: hit = &fieldHit;
      RATE_DAY:   hit = fieldHit[IDX_HOUR] & fieldHit[IDX_MIN] & fieldHit[IDX_SEC];
      RATE_HOUR:  hit = fieldHit[IDX_MIN] & fieldHit[IDX_SEC];
      RATE_MIN:   hit = fieldHit[IDX_SEC];
      default:    hit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= stb.evalTick & hit;
  end

  // R11: the interrupt is a single-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R11: the interrupt only follows an evaluation strobe
  a_r11_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(stb.evalTick));

  // R10: all four masks set fires on every evaluation
  a_r10_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.evalTick && (&maskBits)) |=> irq);

  // R3: the seconds register only ever changes to a legal value
  a_r3_sec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarmReg[IDX_SEC]) |->
      (alarmReg[IDX_SEC][6:4] <= 3'd5 && alarmReg[IDX_SEC][3:0] <= 4'd9));

  // R4: the hours register only ever changes to a legal value
  a_r4_hour_legal: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarmReg[IDX_HOUR]) |->
      (alarmReg[IDX_HOUR][3:0] <= 4'd9 &&
       (alarmReg[IDX_HOUR][5:4] < 2'd2 || alarmReg[IDX_HOUR][3:0] <= 4'd3)));

  // R5: the date register never changes to a zero date
  a_r5_date_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(alarmReg[IDX_DATE]) |-> (alarmReg[IDX_DATE][5:0] != 6'd0));

endmodule

// File: rtl/masked_alarm.sv
module masked_alarm
  import masked_alarm_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int MASK_BIT = 7,
  parameter int SEC_MAX  = 59,
  parameter int MIN_MAX  = 59,
  parameter int HOUR_MAX = 23,
  parameter int DATE_MAX = 39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] todSec,
  input  logic [DATA_W-1:0] todMin,
  input  logic [DATA_W-1:0] todHour,
  input  logic [DATA_W-1:0] todDate,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              alarmIrq
);

  ctrlStrobes_t stb;

  masked_alarm_ctrl #(
    .DATA_W(DATA_W), .SEC_MAX(SEC_MAX), .MIN_MAX(MIN_MAX),
    .HOUR_MAX(HOUR_MAX), .DATE_MAX(DATE_MAX)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .stb(stb)
  );

  masked_alarm_datapath #(
    .DATA_W(DATA_W), .MASK_BIT(MASK_BIT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrData(regWrData), .rdAddr(regAddr),
    .todSec(todSec), .todMin(todMin), .todHour(todHour), .todDate(todDate),
    .rdData(regRdData), .irq(alarmIrq)
  );

endmodule

// File: tb/masked_alarm_tb_top.sv
module masked_alarm_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] todSec = 8'h00, todMin = 8'h00, todHour = 8'h00, todDate = 8'h00;
  logic       regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       alarmIrq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  typedef struct { logic exp; string tag; } sbItem_t;
  sbItem_t sbQ [$];

  always #4 clk = ~clk;

  masked_alarm dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .todSec(todSec), .todMin(todMin), .todHour(todHour), .todDate(todDate),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .alarmIrq(alarmIrq)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: each tick sampled at an edge consumes one expected item
  initial begin
    forever begin
      @(posedge clk);
      if (tick && rst_n) begin
        sbItem_t it;
        if (sbQ.size() == 0) begin
          it.exp = 1'b0; it.tag = "R11 unexpected tick";
        end else begin
          it = sbQ.pop_front();
        end
        @(negedge clk);
        check(alarmIrq === it.exp, it.tag, {7'd0, alarmIrq}, {7'd0, it.exp});
      end
    end
  end

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic checkRead(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    check(regRdData === exp, tag, regRdData, exp);
  endtask

  task automatic setTod(input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic [7:0] d);
    @(negedge clk);
    todSec = s; todMin = m; todHour = h; todDate = d;
  endtask

  task automatic tickOnce(input logic exp, input string tag);
    sbItem_t it;
    @(negedge clk);
    it.exp = exp; it.tag = tag;
    sbQ.push_back(it);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic setAll(input logic [7:0] s, input logic [7:0] m,
                        input logic [7:0] h, input logic [7:0] d);
    writeReg(2'd0, s); writeReg(2'd1, m); writeReg(2'd2, h); writeReg(2'd3, d);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check(alarmIrq === 1'b0, "R1 irq low in reset", {7'd0, alarmIrq}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) checkRead(2'(i), 8'h00, "R1 register clear");

    // R2: write and read back
    setAll(8'h30, 8'h45, 8'h12, 8'h15);
    checkRead(2'd0, 8'h30, "R2 seconds readback");
    checkRead(2'd1, 8'h45, "R2 minutes readback");
    checkRead(2'd2, 8'h12, "R2 hours readback");
    checkRead(2'd3, 8'h15, "R2 date readback");

    // R6: monthly, everything must match
    setTod(8'h30, 8'h45, 8'h12, 8'h15);
    tickOnce(1'b1, "R6 full match fires");
    setTod(8'h31, 8'h45, 8'h12, 8'h15);
    tickOnce(1'b0, "R6 seconds differ");
    setTod(8'h30, 8'h45, 8'h12, 8'h16);
    tickOnce(1'b0, "R6 date differs");

    // R3: seconds/minutes legality
    writeReg(2'd0, 8'h60);
    checkRead(2'd0, 8'h30, "R3 seconds 60 rejected");
    writeReg(2'd0, 8'h1A);
    checkRead(2'd0, 8'h30, "R3 seconds nibble A rejected");
    writeReg(2'd0, 8'hD9);
    checkRead(2'd0, 8'hD9, "R3 seconds 59 with mask accepted");
    writeReg(2'd0, 8'h30);
    writeReg(2'd1, 8'h5A);
    checkRead(2'd1, 8'h45, "R3 minutes nibble A rejected");

    // R4: hours legality
    writeReg(2'd2, 8'h24);
    checkRead(2'd2, 8'h12, "R4 hours 24 rejected");
    writeReg(2'd2, 8'h0C);
    checkRead(2'd2, 8'h12, "R4 hours nibble C rejected");
    writeReg(2'd2, 8'h23);
    checkRead(2'd2, 8'h23, "R4 hours 23 accepted");

    // R5: date legality
    writeReg(2'd3, 8'h00);
    checkRead(2'd3, 8'h15, "R5 date zero rejected");
    writeReg(2'd3, 8'h80);
    checkRead(2'd3, 8'h15, "R5 masked date zero rejected");
    writeReg(2'd3, 8'h31);
    checkRead(2'd3, 8'h31, "R5 date 31 accepted");
    writeReg(2'd3, 8'h15);

    // R12: hours bit 6 does not take part in the match
    writeReg(2'd2, 8'h52);
    checkRead(2'd2, 8'h52, "R12 hours bit6 stored");
    setTod(8'h30, 8'h45, 8'h12, 8'h15);
    tickOnce(1'b1, "R12 hours bit6 ignored in match");

    // R7: daily
    setAll(8'h30, 8'h45, 8'h12, 8'h95);
    setTod(8'h30, 8'h45, 8'h12, 8'h20);
    tickOnce(1'b1, "R7 date ignored");
    setTod(8'h30, 8'h45, 8'h13, 8'h20);
    tickOnce(1'b0, "R7 hours differ");

    // R8: hourly
    writeReg(2'd2, 8'h92);
    setTod(8'h30, 8'h45, 8'h05, 8'h03);
    tickOnce(1'b1, "R8 hours and date ignored");
    setTod(8'h30, 8'h46, 8'h05, 8'h03);
    tickOnce(1'b0, "R8 minutes differ");

    // R9: once a minute
    writeReg(2'd1, 8'hC5);
    setTod(8'h30, 8'h10, 8'h05, 8'h03);
    tickOnce(1'b1, "R9 only seconds compared");
    setTod(8'h31, 8'h10, 8'h05, 8'h03);
    tickOnce(1'b0, "R9 seconds differ");

    // R10: other patterns fire every tick
    writeReg(2'd0, 8'hB0);
    tickOnce(1'b1, "R10 all masks set");
    setAll(8'hB0, 8'h45, 8'h12, 8'h15);
    setTod(8'h01, 8'h02, 8'h03, 8'h04);
    tickOnce(1'b1, "R10 seconds mask alone");
    setAll(8'h30, 8'hC5, 8'h12, 8'h95);
    tickOnce(1'b1, "R10 date and minutes masked");

    // R11: held tick gives one pulse; no tick gives none
    begin
      sbItem_t it;
      @(negedge clk);
      it.exp = 1'b1; it.tag = "R11 held tick first cycle";  sbQ.push_back(it);
      it.exp = 1'b0; it.tag = "R11 held tick second cycle"; sbQ.push_back(it);
      it.exp = 1'b0; it.tag = "R11 held tick third cycle";  sbQ.push_back(it);
      tick = 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(alarmIrq === 1'b0, "R11 no pulse without tick", {7'd0, alarmIrq}, 8'h00);
    end

    repeat (2) @(negedge clk);
    check(sbQ.size() == 0, "R11 scoreboard drained", 8'(sbQ.size()), 8'h00);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule